// File: doc/BRIEF.md
# Camera Register Boot Sequencer

This block configures an image sensor once, right after reset, with no command from elsewhere. It holds a small constant list of register writes. For each entry it sends one write-only transaction on a two-wire serial bus made of a clock line (SIOC) and a data line (SIOD). Each transaction has three bytes: the sensor's write identifier, then the register number, then the value. The data line is open-drain: the block only ever pulls it low through an enable and otherwise lets it float high. A divider built from the system clock frequency sets the bus clock to 100 kHz. Each bit period is cut into four equal quarter phases, so that data edges fall strictly between clock edges.

The first entry is a soft reset of the sensor. The sensor drops the write that comes straight after a soft reset. For that reason the second entry is a throwaway write of a harmless value, and it comes after a programmable quiet gap. The real format settings follow it. A busy flag covers the whole run. A done flag rises after the last stop condition and then stays high. Acknowledge bits are neither sampled nor checked.

Top module: `cam_init_seq`

## Requirements
- R1: While reset is asserted, SIOC is high, the SIOD pull-down enable is off (line released high), and both busy and done are low.
- R2: A transaction opens with a start condition: SIOD goes from high to low while SIOC stays high, and no start appears inside an open transaction.
- R3: A transaction closes with a stop condition: SIOD goes from low to high while SIOC stays high, after exactly 27 SIOC high pulses (three 9-bit byte slots).
- R4: Between start and stop, SIOD changes level only while SIOC is low.
- R5: Each byte goes out most significant bit first, and the first byte of every transaction is the write identifier 0x42.
- R6: The ninth bit slot after each byte (slots 9, 18 and 27) leaves SIOD released, so the line reads high.
- R7: A quarter phase lasts CLK_HZ/(4*BUS_HZ) system clocks, and every data-bit SIOC high pulse lasts exactly two quarter phases.
- R8: The writes go out in this order as (register, value): (0x12,0x80) soft reset, (0x11,0x80) throwaway, (0x12,0x04), (0x40,0xD0), (0x8C,0x00), (0x3A,0x04).
- R9: The stop of the soft-reset write and the next start are at least (CLK_HZ/1000)*GAP_US/1000 system clocks apart. Every other gap between transactions is shorter than that.
- R10: Busy rises within three clocks after reset is released and stays high until done rises. Busy and done are never high together, and done never falls once raised.
- R11: Exactly six transactions are sent. After done, SIOC stays high and SIOD stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sioc_o | output | 1 | Serial bus clock, driven push-pull |
| siod_oe_o | output | 1 | Pull-down enable for the open-drain data line (1 = drive low) |
| busy_o | output | 1 | High while the write list is being sent |
| done_o | output | 1 | Sticky flag, high once the last write has been sent |

## Verification
A corrupted phase counter or shift register shows up on the bus within one bit period, about four quarter phases. It appears as a high pulse of the wrong width, a data edge while SIOC is high that looks like a spurious start or stop, or a byte that differs from the table. A slip in the list index appears at the next stop as a register/value pair out of order, or as a gap that is too long or too short. A wrong final state shows as busy and done overlapping, or as bus activity after done.

// File: rtl/cis_pkg.sv
package cis_pkg;

    localparam int         ENTRY_COUNT  = 6;
    localparam int         IDX_W        = $clog2(ENTRY_COUNT);
    localparam int         FRAME_BITS   = 27;
    localparam logic [7:0] DEV_WRITE_ID = 8'h42;

    typedef struct packed {
        logic [7:0] sub;
        logic [7:0] val;
    } reg_write_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_BITS,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_GAP,
        SQ_FIN
    } seq_state_e;

endpackage

// File: rtl/cis_tick_gen.sv
module cis_tick_gen #(
    parameter int QDIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(QDIV - 1)) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + CW'(1);
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    // R7: consecutive ticks are never adjacent when a quarter phase spans several clocks
    a_r7_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (QDIV > 1 && tick_o) |=> !tick_o);

endmodule

// File: rtl/cis_rom.sv
module cis_rom
    import cis_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output reg_write_t       entry_o
);
    always_comb begin
        case (idx_i)
            IDX_W'(0): entry_o = '{sub: 8'h12, val: 8'h80}; // soft reset
            IDX_W'(1): entry_o = '{sub: 8'h11, val: 8'h80}; // throwaway write
            IDX_W'(2): entry_o = '{sub: 8'h12, val: 8'h04}; // output format
            IDX_W'(3): entry_o = '{sub: 8'h40, val: 8'hD0}; // 16-bit colour range
            IDX_W'(4): entry_o = '{sub: 8'h8C, val: 8'h00}; // alternate colour mode off
            IDX_W'(5): entry_o = '{sub: 8'h3A, val: 8'h04}; // line buffer order
            default:   entry_o = '{sub: 8'h00, val: 8'h00};
        endcase
    end
endmodule

// File: rtl/cis_wire_tx.sv
module cis_wire_tx
    import cis_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       go_i,
    input  logic [7:0] dev_i,
    input  logic [7:0] sub_i,
    input  logic [7:0] val_i,
    output logic       sioc_o,
    output logic       siod_oe_o,
    output logic       done_o
);
    typedef struct packed {
        tx_state_e              st;
        logic [1:0]             ph;
        logic [4:0]             bitn;
        logic [FRAME_BITS-1:0]  sh;
        logic                   done;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            TX_IDLE: begin
                if (go_i) begin
                    s_d.st   = TX_START;
                    s_d.ph   = 2'd0;
                    s_d.bitn = 5'd0;
                    s_d.sh   = {dev_i, 1'b1, sub_i, 1'b1, val_i, 1'b1};
                end
            end
            TX_START: begin
                if (tick_i) begin
                    if (s_q.ph == 2'd3) begin
                        s_d.st = TX_BITS;
                        s_d.ph = 2'd0;
                    end else begin
                        s_d.ph = s_q.ph + 2'd1;
                    end
                end
            end
            TX_BITS: begin
                if (tick_i) begin
                    if (s_q.ph == 2'd3) begin
                        s_d.ph = 2'd0;
                        s_d.sh = {s_q.sh[FRAME_BITS-2:0], 1'b1};
                        if (s_q.bitn == 5'(FRAME_BITS - 1)) s_d.st = TX_STOP;
                        else                                s_d.bitn = s_q.bitn + 5'd1;
                    end else begin
                        s_d.ph = s_q.ph + 2'd1;
                    end
                end
            end
            TX_STOP: begin
                if (tick_i) begin
                    if (s_q.ph == 2'd3) begin
                        s_d.st   = TX_IDLE;
                        s_d.ph   = 2'd0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph = s_q.ph + 2'd1;
                    end
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= TX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // Phase decode: bit slots are low / high / high / low; data moves in phase 0.
    always_comb begin
        case (s_q.st)
            TX_START: begin
                sioc_o    = (s_q.ph != 2'd3);
                siod_oe_o = (s_q.ph != 2'd0);
            end
            TX_BITS: begin
                sioc_o    = (s_q.ph == 2'd1) || (s_q.ph == 2'd2);
                siod_oe_o = ~s_q.sh[FRAME_BITS-1];
            end
            TX_STOP: begin
                sioc_o    = (s_q.ph != 2'd0);
                siod_oe_o = (s_q.ph < 2'd2);
            end
            default: begin
                sioc_o    = 1'b1;
                siod_oe_o = 1'b0;
            end
        endcase
    end

    assign done_o = s_q.done;

    // R4: a data-line edge under a steady high clock only happens in start or stop
    a_r4_data_moves_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sioc_o && $stable(sioc_o) && !$stable(siod_oe_o)) |->
            (s_q.st == TX_START || s_q.st == TX_STOP));

    // R6: acknowledge slots leave the line released
    a_r6_ack_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == TX_BITS && (s_q.bitn == 5'd8 || s_q.bitn == 5'd17 || s_q.bitn == 5'd26))
            |-> !siod_oe_o);

    // R3: the bit counter never runs past the last slot of a frame
    a_r3_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == TX_BITS) |-> (s_q.bitn < 5'(FRAME_BITS)));

    // R2: a frame opens with the line falling while the clock is high
    a_r2_start_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(siod_oe_o) && s_q.st == TX_START |-> sioc_o);

endmodule

// File: rtl/cam_init_seq.sv
module cam_init_seq
    import cis_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BUS_HZ = 100_000,
    parameter int GAP_US = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic sioc_o,
    output logic siod_oe_o,
    output logic busy_o,
    output logic done_o
);
    localparam int QDIV_RAW = CLK_HZ / (4 * BUS_HZ);
    localparam int QDIV     = (QDIV_RAW > 0) ? QDIV_RAW : 1;
    localparam int GAP_RAW  = (CLK_HZ / 1000) * GAP_US / 1000;
    localparam int GAP_CYC  = (GAP_RAW > 1) ? GAP_RAW : 1;
    localparam int GW       = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [GW-1:0]     gap;
    } seq_st_t;

    seq_st_t    s_d, s_q;
    logic       tick;
    logic       go;
    logic       tx_done;
    reg_write_t entry;

    cis_tick_gen #(.QDIV(QDIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    cis_rom u_rom (
        .idx_i   (s_q.idx),
        .entry_o (entry)
    );

    cis_wire_tx u_tx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .go_i      (go),
        .dev_i     (DEV_WRITE_ID),
        .sub_i     (entry.sub),
        .val_i     (entry.val),
        .sioc_o    (sioc_o),
        .siod_oe_o (siod_oe_o),
        .done_o    (tx_done)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SQ_BOOT:   s_d.st = SQ_LAUNCH;
            SQ_LAUNCH: s_d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (tx_done) begin
                    if (s_q.idx == IDX_W'(ENTRY_COUNT - 1)) begin
                        s_d.st = SQ_FIN;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                        if (s_q.idx == '0) begin
                            s_d.st  = SQ_GAP;
                            s_d.gap = GW'(GAP_CYC - 1);
                        end else begin
                            s_d.st = SQ_LAUNCH;
                        end
                    end
                end
            end
            SQ_GAP: begin
                if (s_q.gap == '0) s_d.st  = SQ_LAUNCH;
                else               s_d.gap = s_q.gap - GW'(1);
            end
            SQ_FIN:  s_d.st = SQ_FIN;
            default: s_d.st = SQ_BOOT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q    <= '0;
            s_q.st <= SQ_BOOT;
        end else begin
            s_q <= s_d;
        end
    end

    assign go     = (s_q.st == SQ_LAUNCH);
    assign busy_o = (s_q.st == SQ_LAUNCH) || (s_q.st == SQ_WAIT) || (s_q.st == SQ_GAP);
    assign done_o = (s_q.st == SQ_FIN);

    // R10: done is sticky
    a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o);

    // R10: busy and done exclude each other
    a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    // R11: the bus is idle once the list is finished
    a_r11_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (sioc_o && !siod_oe_o));

    // R9: the long gap only follows the soft-reset write
    a_r9_gap_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == SQ_GAP) |-> (s_q.idx == IDX_W'(1)));

    // R8: a launch never reads past the end of the list
    a_r8_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go |-> (s_q.idx < IDX_W'(ENTRY_COUNT)));

endmodule

// File: tb/test_cam_init_seq.sv
module test_cam_init_seq;

    localparam int CLK_HZ  = 1_600_000;
    localparam int BUS_HZ  = 100_000;
    localparam int GAP_US  = 1000;
    localparam int QDIV    = CLK_HZ / (4 * BUS_HZ);
    localparam int GAP_CYC = (CLK_HZ / 1000) * GAP_US / 1000;
    localparam int N_WR    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sioc, oe, busy, done;

    always #4 clk = ~clk;

    cam_init_seq #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .GAP_US(GAP_US)) i_cam_init_seq (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sioc_o    (sioc),
        .siod_oe_o (oe),
        .busy_o    (busy),
        .done_o    (done)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [23:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_write(input logic [7:0] sub, input logic [7:0] val);
        exp_q.push_back({8'h42, sub, val});
    endtask

    // monitor state
    logic        prev_sioc = 1'b1, prev_oe = 1'b0, prev_done = 1'b0;
    bit          in_frame = 0, rise_ok = 0;
    int          bitn = 0, rise_t = 0, last_stop = 0, frames = 0;
    int          excl_bad = 0, drop_bad = 0;
    logic [26:0] bits = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done && busy) excl_bad++;
            if (prev_done && !done) drop_bad++;
            if (sioc && prev_sioc && oe && !prev_oe) begin
                check(!in_frame, "R2", "start inside open frame", 1, 0);
                if (frames > 0) begin
                    if (frames == 1)
                        check(cyc - last_stop >= GAP_CYC, "R9", "gap after soft reset", cyc - last_stop, GAP_CYC);
                    else
                        check(cyc - last_stop < GAP_CYC, "R9", "short gap", cyc - last_stop, GAP_CYC);
                end
                in_frame = 1; bitn = 0; bits = '0; rise_ok = 0;
            end else if (sioc && prev_sioc && !oe && prev_oe) begin
                check(in_frame && bitn == 27, "R3", "slots before stop", bitn, 27);
                if (exp_q.size() == 0) begin
                    check(0, "R11", "unexpected extra write", int'(bits), 0);
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check(bits[26:19] == e[23:16], "R5", "device id byte", bits[26:19], e[23:16]);
                    check(bits[17:10] == e[15:8], "R8", "register byte", bits[17:10], e[15:8]);
                    check(bits[8:1] == e[7:0], "R8", "value byte", bits[8:1], e[7:0]);
                end
                in_frame = 0; rise_ok = 0; last_stop = cyc; frames++;
            end else if (sioc && !prev_sioc) begin
                rise_t = cyc; rise_ok = in_frame;
            end else if (!sioc && prev_sioc && rise_ok) begin
                check(cyc - rise_t == 2 * QDIV, "R7", "clock high width", cyc - rise_t, 2 * QDIV);
                if (bitn % 9 == 8) check(!oe, "R6", "ack slot released", oe, 0);
                bits = {bits[25:0], ~oe};
                bitn++;
                rise_ok = 0;
            end else if (sioc && prev_sioc && oe != prev_oe) begin
                check(0, "R4", "data edge under high clock", oe, prev_oe);
            end
        end
        prev_sioc = sioc; prev_oe = oe; prev_done = done;
    end

    initial begin
        int quiet_bad;
        push_write(8'h12, 8'h80);
        push_write(8'h11, 8'h80);
        push_write(8'h12, 8'h04);
        push_write(8'h40, 8'hD0);
        push_write(8'h8C, 8'h00);
        push_write(8'h3A, 8'h04);

        repeat (4) @(negedge clk);
        check(sioc == 1'b1, "R1", "sioc in reset", sioc, 1);
        check(oe == 1'b0, "R1", "oe in reset", oe, 0);
        check(busy == 1'b0 && done == 1'b0, "R1", "flags in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy && !done, "R10", "busy after reset", {busy, done}, 2'b10);

        while (!done && cyc < 100000) @(negedge clk);
        check(done == 1'b1, "R10", "done reached", done, 1);
        check(frames == N_WR, "R11", "writes at done", frames, N_WR);
        check(exp_q.size() == 0, "R8", "writes still pending", exp_q.size(), 0);

        quiet_bad = 0;
        repeat (2000) begin
            @(negedge clk);
            if (!done || busy || !sioc || oe) quiet_bad++;
        end
        check(quiet_bad == 0, "R11", "bus quiet after done", quiet_bad, 0);
        check(frames == N_WR, "R11", "no write after done", frames, N_WR);
        check(excl_bad == 0, "R10", "busy and done together", excl_bad, 0);
        check(drop_bad == 0, "R10", "done dropped", drop_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule